// File: doc/BRIEF.md
# Software-Driven Display Identification Two-Wire Port

This block gives software direct control of an open-drain clock line and data line, used to read identification data from an attached monitor. Software writes one 32-bit control word holding a drive value and a drive enable for each line. Each line is either pulled low or released to its pull-up. The sensed level of each line comes back in two separate readback bits. Every field sits at a fixed distance from a base bit position chosen by parameter. There is no protocol engine: software produces each START, bit, acknowledge and STOP by writing the word over and over.

The word accepts 1-, 2- and 4-byte writes, given as byte enables. A second variant of the block guards the pads against glitches that multi-byte drivers cause when they update the word one byte at a time. In that variant, a write reaches the pads only when a master mask bit is set and the write has the right byte coverage. The stored word always takes the new bytes, whether or not the pads change. When the pads do change, the clock line changes one cycle before the data line.

Top module: `ddc_gpio_port`

## Requirements
- R1: After synchronous reset the stored word reads as zero, apart from the readback bits. Both pull-down outputs are high (lines released). Both readback bits read 1.
- R2: With base bit B: the data drive value is at bit B and the clock drive value is at bit B+1. The data enable is at bit B+16 and the clock enable at bit B+17. When a line is updated and its enable is 1 with value 0, its active-low pull-down output goes to 0. In every other case the output goes to 1 (released).
- R3: A write changes only the byte lanes whose `wr_be` bit is 1. The other lanes keep their stored contents.
- R4: Sensed data appears at read bit B+8 and sensed clock at read bit B+9. Each passes through a two-flop synchroniser, so a change on a pad input is visible in `rd_data` two clock edges later. Data written to these two bits is discarded.
- R5: On a pad update, the clock pull-down output changes at the clock edge that takes the write. The data pull-down output changes one edge later.
- R6: In the ungated variant (`MASK_GATED`=0, B=0), every write updates both pads from the merged word.
- R7: In the gated variant (`MASK_GATED`=1, B=1), no write updates the pads while bit 25 of the merged word is 0.
- R8: In the gated variant with bit 25 of the merged word set, a write updates the pads in either of two cases. The first is a write to byte lane 2. The second is a write to byte lane 0 while bit 17 or bit 18 of the merged word is 1. A write that meets neither case stores its data but leaves both pads unchanged.
- R9: All bits other than the two readback bits read back exactly as last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data, lane aligned |
| rd_data | output | 32 | Stored word with live readback bits |
| scl_in | input | 1 | Sensed clock pad level |
| sda_in | input | 1 | Sensed data pad level |
| scl_pd_n | output | 1 | Clock pad pull-down, active low |
| sda_pd_n | output | 1 | Data pad pull-down, active low |

## Verification
Both variants receive the same stream of writes at the same time, so each write's effect differs with the base position and the gating rule. Directed writes set the enables with values low, then release them. Single-lane writes to lanes 0, 2 and 3 separate the coverage rule from the mask rule, and a write to lane 3 alone shows data being stored without reaching the pads. An external device pulling the lines low, timed independently of the writes, shows the two-edge readback delay and that the sensed level, not the driven value, is what reads back. A long run of random legal byte-enable patterns then compares all outputs on every cycle against the model.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_pair_t;

    // Merge enabled byte lanes of new data into an old word.
    function automatic logic [31:0] merge_lanes(input logic [31:0] old_w,
                                                input logic [31:0] new_w,
                                                input logic [3:0]  be);
        logic [31:0] r;
        r = old_w;
        for (int l = 0; l < 4; l++) begin
            if (be[l]) r[8*l +: 8] = new_w[8*l +: 8];
        end
        return r;
    endfunction

    // Active-low pull-down: pull only when enabled and driving zero.
    function automatic logic pad_pd_n(input logic en, input logic val);
        return ~(en & ~val);
    endfunction

endpackage

// File: rtl/ddc_gpio_regs.sv
module ddc_gpio_regs
    import ddc_gpio_pkg::*;
#(
    parameter int BASE_BIT   = 0,
    parameter bit MASK_GATED = 1'b0,
    parameter int MASK_BIT   = 25
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] stored,
    output logic [31:0] merged,
    output logic        upd
);
    localparam int SDA_RB  = BASE_BIT + 8;
    localparam int SCL_RB  = BASE_BIT + 9;
    localparam int SDA_EN  = BASE_BIT + 16;
    localparam int SCL_EN  = BASE_BIT + 17;
    localparam int EN_LANE = SDA_EN / 8;

    logic gate_ok;

    always_comb begin
        merged         = merge_lanes(stored, wr_data, wr_be);
        merged[SDA_RB] = 1'b0;
        merged[SCL_RB] = 1'b0;
    end

    generate
        if (MASK_GATED) begin : g_gated
            assign gate_ok = merged[MASK_BIT] &&
                             (wr_be[EN_LANE] ||
                              (wr_be[0] && (merged[SDA_EN] || merged[SCL_EN])));
        end else begin : g_open
            assign gate_ok = 1'b1;
        end
    endgenerate

    assign upd = wr_en && gate_ok;

    always_ff @(posedge clk) begin
        if (rst)        stored <= '0;
        else if (wr_en) stored <= merged;
    end

    // R3
    stored_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> stored == $past(stored));

endmodule

// File: rtl/ddc_gpio_sync.sv
module ddc_gpio_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)         chain[s] <= '1;
                else if (s == 0) chain[s] <= d;
                else             chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ddc_gpio_drive.sv
module ddc_gpio_drive
    import ddc_gpio_pkg::*;
#(
    parameter int BASE_BIT = 0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        upd,
    input  logic [31:0] merged,
    output line_pair_t  pd_n
);
    localparam int SDA_OUT = BASE_BIT;
    localparam int SCL_OUT = BASE_BIT + 1;
    localparam int SDA_EN  = BASE_BIT + 16;
    localparam int SCL_EN  = BASE_BIT + 17;

    logic sda_pend;
    logic pend_v;

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_n     <= '{scl: 1'b1, sda: 1'b1};
            sda_pend <= 1'b1;
            pend_v   <= 1'b0;
        end else begin
            pend_v <= upd;
            if (upd) begin
                pd_n.scl <= pad_pd_n(merged[SCL_EN], merged[SCL_OUT]);
                sda_pend <= pad_pd_n(merged[SDA_EN], merged[SDA_OUT]);
            end
            if (pend_v) pd_n.sda <= sda_pend;
        end
    end

    // R5
    sda_after_scl_chk: assert property (@(posedge clk) disable iff (rst)
        !pend_v |=> $stable(pd_n.sda));

endmodule

// File: rtl/ddc_gpio_port.sv
module ddc_gpio_port
    import ddc_gpio_pkg::*;
#(
    parameter int BASE_BIT    = 0,
    parameter bit MASK_GATED  = 1'b0,
    parameter int MASK_BIT    = 25,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    input  logic        scl_in,
    input  logic        sda_in,
    output logic        scl_pd_n,
    output logic        sda_pd_n
);
    localparam int SDA_RB = BASE_BIT + 8;
    localparam int SCL_RB = BASE_BIT + 9;

    logic [31:0] stored, merged;
    logic        upd;
    line_pair_t  sensed, drv;

    ddc_gpio_regs #(.BASE_BIT(BASE_BIT), .MASK_GATED(MASK_GATED),
                    .MASK_BIT(MASK_BIT)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .stored(stored), .merged(merged), .upd(upd));

    ddc_gpio_drive #(.BASE_BIT(BASE_BIT)) drive_i (
        .clk(clk), .rst(rst), .upd(upd), .merged(merged), .pd_n(drv));

    ddc_gpio_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) sync_i (
        .clk(clk), .rst(rst), .d({scl_in, sda_in}), .q(sensed));

    always_comb begin
        rd_data         = stored;
        rd_data[SDA_RB] = sensed.sda;
        rd_data[SCL_RB] = sensed.scl;
    end

    assign scl_pd_n = drv.scl;
    assign sda_pd_n = drv.sda;

    // R5
    scl_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(scl_pd_n));

    generate
        if (MASK_GATED) begin : g_mask_chk
            // R7
            mask_block_chk: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_be[MASK_BIT/8] && !wr_data[MASK_BIT]) |=> $stable(scl_pd_n));
        end
        if (SYNC_STAGES == 2) begin : g_rb_chk
            // R4
            rb_rise_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(rd_data[SDA_RB]) |-> $past(sda_in, 2));
        end
    endgenerate

endmodule

// File: tb/ddc_gpio_port_tb.sv
module ddc_gpio_port_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = 4'h0;
    logic [31:0] wr_data = '0;
    logic        ext_scl_low = 1'b0;
    logic        ext_sda_low = 1'b0;

    logic [31:0] rd_i, rd_g;
    logic        scl_pd_i, sda_pd_i, scl_pd_g, sda_pd_g;
    logic        scl_line_i, sda_line_i, scl_line_g, sda_line_g;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    assign scl_line_i = scl_pd_i & ~ext_scl_low;
    assign sda_line_i = sda_pd_i & ~ext_sda_low;
    assign scl_line_g = scl_pd_g & ~ext_scl_low;
    assign sda_line_g = sda_pd_g & ~ext_sda_low;

    ddc_gpio_port #(.BASE_BIT(0), .MASK_GATED(1'b0)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_i), .scl_in(scl_line_i), .sda_in(sda_line_i),
        .scl_pd_n(scl_pd_i), .sda_pd_n(sda_pd_i));

    ddc_gpio_port #(.BASE_BIT(1), .MASK_GATED(1'b1)) dut_g (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .rd_data(rd_g), .scl_in(scl_line_g), .sda_in(sda_line_g),
        .scl_pd_n(scl_pd_g), .sda_pd_n(sda_pd_g));

    // Behavioural reference: index 0 = ungated base 0, index 1 = gated base 1
    logic [31:0] m_reg [2];
    logic        m_scl [2];
    logic        m_sda [2];
    logic        m_pend[2];
    logic        m_pv  [2];
    logic [1:0]  m_s1  [2];
    logic [1:0]  m_s2  [2];

    task automatic model_step(input int k);
        int          b;
        logic [31:0] mer;
        logic        go, lscl, lsda, old_pv, old_p;
        b = k;
        if (rst) begin
            m_reg[k] = '0; m_scl[k] = 1'b1; m_sda[k] = 1'b1;
            m_pend[k] = 1'b1; m_pv[k] = 1'b0;
            m_s1[k] = 2'b11; m_s2[k] = 2'b11;
        end else begin
            lscl = m_scl[k] & ~ext_scl_low;
            lsda = m_sda[k] & ~ext_sda_low;
            m_s2[k] = m_s1[k];
            m_s1[k] = {lscl, lsda};
            old_pv = m_pv[k];
            old_p  = m_pend[k];
            m_pv[k] = 1'b0;
            if (wr_en) begin
                mer = m_reg[k];
                for (int l = 0; l < 4; l++)
                    if (wr_be[l]) mer[8*l +: 8] = wr_data[8*l +: 8];
                mer[b+8] = 1'b0;
                mer[b+9] = 1'b0;
                m_reg[k] = mer;
                if (k == 1) go = mer[25] && (wr_be[2] || (wr_be[0] && (mer[17] || mer[18])));
                else        go = 1'b1;
                if (go) begin
                    m_scl[k]  = !(mer[b+17] && !mer[b+1]);
                    m_pend[k] = !(mer[b+16] && !mer[b]);
                    m_pv[k]   = 1'b1;
                end
            end
            if (old_pv) m_sda[k] = old_p;
        end
    endtask

    always @(posedge clk) begin
        model_step(0);
        model_step(1);
    end

    function automatic logic [31:0] exp_rd(input int k);
        logic [31:0] r;
        r = m_reg[k];
        r[k+8] = m_s2[k][0];
        r[k+9] = m_s2[k][1];
        return r;
    endfunction

    task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cmp("R1 R3 R4 R9 dut_i rd_data", rd_i, exp_rd(0));
            cmp("R1 R2 R5 R6 dut_i scl_pd_n", {31'd0, scl_pd_i}, {31'd0, m_scl[0]});
            cmp("R1 R2 R5 R6 dut_i sda_pd_n", {31'd0, sda_pd_i}, {31'd0, m_sda[0]});
            cmp("R1 R3 R4 R9 dut_g rd_data", rd_g, exp_rd(1));
            cmp("R1 R2 R5 R7 R8 dut_g scl_pd_n", {31'd0, scl_pd_g}, {31'd0, m_scl[1]});
            cmp("R1 R2 R5 R7 R8 dut_g sda_pd_n", {31'd0, sda_pd_g}, {31'd0, m_sda[1]});
        end
    end

    task automatic wrt(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 4'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    logic [3:0] be_opts [6];

    initial begin
        be_opts = '{4'b0001, 4'b0100, 4'b1000, 4'b0011, 4'b1100, 4'b1111};
        idle(3);
        rst = 1'b0;
        idle(3);                                 // R1 reset state
        wrt(4'hF, 32'h0003_0000);                // R2 R6: both enabled, values low
        idle(3);
        wrt(4'hF, 32'h0003_0003);                // R2: enabled, values high -> release
        idle(3);
        wrt(4'hF, 32'h0206_0300);                // R8 lane 2 with mask; R4 readback bits written
        idle(3);
        wrt(4'h1, 32'h0000_0000);                // R8 lane 0 while enables set
        idle(3);
        wrt(4'h8, 32'h0000_0000);                // R7 mask cleared, no pad change in gated
        idle(2);
        wrt(4'h1, 32'h0000_0006);                // R7 no update without mask
        idle(2);
        wrt(4'h8, 32'h0200_0000);                // R8 lane 3 only: stored, not applied
        idle(2);
        wrt(4'h3, 32'hA5A5_0006);                // R3 R8 lane 0 with enables -> release
        idle(2);
        wrt(4'h4, 32'h0000_0000);                // R8 lane 2 clears enables
        idle(2);
        ext_sda_low = 1'b1; idle(4);             // R4 external pull on data
        ext_scl_low = 1'b1; idle(1); ext_sda_low = 1'b0; idle(4);
        ext_scl_low = 1'b0; idle(3);
        wrt(4'hC, 32'hDEAD_0000);                // R9 upper half
        idle(2);
        for (int i = 0; i < 600; i++) begin      // mixed random traffic
            @(negedge clk);
            wr_en       = ($urandom % 3) == 0;
            wr_be       = be_opts[$urandom % 6];
            wr_data     = $urandom;
            ext_scl_low = ($urandom % 7) == 0;
            ext_sda_low = ($urandom % 5) == 0;
        end
        @(negedge clk);
        wr_en = 1'b0; ext_scl_low = 1'b0; ext_sda_low = 1'b0;
        idle(4);
        rst = 1'b1; idle(2); rst = 1'b0;         // R1 reset again
        idle(3);
        finish_run();
    end

endmodule